// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the datapath arithmetic unit of a small 8-bit microcontroller core. It is purely combinational: two 8-bit operands, a 4-bit operation code and the current carry flag go in; an 8-bit result, six status flag values and six per-flag write enables come out in the same cycle. The surrounding core writes each flag into its status register only when the matching enable is high, so each operation changes exactly the flags it owns and leaves the rest alone.

The unit covers addition and subtraction with and without an incoming carry, two's complement negation, increment, decrement, the three bitwise operations, one's complement, test, clear and set. Register file access, immediate decoding and multiplication live elsewhere in the core.

Flag vector layout, used by both `flags` and `flag_we`: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 two's-complement overflow (V), bit 4 sign (S), bit 5 half-carry (H).

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) give result = A + B + k (k = carry_in for code 1, else 0), with C = carry out of bit 7, V = signed overflow, H = carry out of bit 3, and flag_we = 6'b111111.
- R2: Codes 2 (subtract) and 3 (subtract with carry) give result = A − B − k (k = carry_in for code 3, else 0), with C = 1 on borrow out of bit 7, V = signed overflow, H = 1 on borrow into bit 4, and flag_we = 6'b111111.
- R3: Code 8 (negate) gives result = 0x00 − A with C, V and H taken as for a subtraction from zero, and flag_we = 6'b111111.
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result of A and B, force V to 0, and set flag_we = 6'b011110 (Z, N, V, S only).
- R5: Code 7 (one's complement) gives result = 0xFF − A, sets C to 1, forces V to 0, and sets flag_we = 6'b011111.
- R6: Codes 9 (increment) and 10 (decrement) give A + 1 and A − 1 modulo 256, set V only for input 0x7F (increment) or 0x80 (decrement), and set flag_we = 6'b011110 so C and H are never written.
- R7: Code 11 (test) gives A AND A and code 12 (clear) gives A XOR A (always 0x00); both force V to 0 and set flag_we = 6'b011110.
- R8: Code 13 (set) gives result 0xFF and flag_we = 0.
- R9: Whenever S is enabled, S = N XOR V.
- R10: The half-carry flag reflects the nibble boundary: H = 1 for 0x0F + 0x01 and for 0x10 − 0x01.
- R11: Codes 14 and 15 are unused: result 0x00 and flag_we = 0.
- R12: Whenever Z is enabled, Z = 1 exactly when the 8-bit result is 0x00, and N equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (A) |
| op_b | input | 8 | Second operand (B) |
| op_sel | input | 4 | Operation code, values listed in the requirements |
| carry_in | input | 1 | Current carry flag, used by codes 1 and 3 |
| result | output | 8 | Operation result |
| flags | output | 6 | Flag values {H,S,V,N,Z,C} |
| flag_we | output | 6 | Per-flag write enables, same layout as flags |

## Verification
The bench sweeps every operation code against all 256 values of A, a set of B values clustered at the nibble and sign boundaries, and both carry values, comparing against an integer model. Signed-boundary operands (0x7F, 0x80) catch an overflow formula that looks at the wrong operand polarity for subtraction, and nibble-boundary operands catch a half-carry that reports carry instead of borrow. Subtract-with-carry at 0x00 − 0x00 − 1 and negation of 0x00 and 0x80 expose inverted borrow sense, while increment and decrement at any value would show up as a wrongly raised carry or half-carry enable.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the 8-bit ALU: operation codes and flag bit positions.
// Assumes the status register consumer decodes flags with the indices below.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_TST  = 4'd11,
        OP_CLR  = 4'd12,
        OP_SER  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    localparam int NFLAGS = 6;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_N   = 2;
    localparam int FL_V   = 3;
    localparam int FL_S   = 4;
    localparam int FL_H   = 5;

    typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Shared adder/subtractor. Subtraction is done as x + ~y + ~borrow; the carry
// and half-carry outputs are converted back to borrow sense when sub is high.
// Assumes W is even so the half-carry boundary sits at W/2.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HALF = W / 2;

    logic [W-1:0]  y_eff;
    logic          c_eff;
    logic [HALF:0] low_sum;
    logic [W:0]    full_sum;

    // Invert the second operand and carry-in for subtraction.
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
    end

    // Form the low-nibble and full-width sums.
    always_comb begin
        low_sum  = {1'b0, x[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
        full_sum = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    end

    // Derive result, carry/borrow, half-carry/borrow and signed overflow.
    always_comb begin
        sum   = full_sum[W-1:0];
        c_out = full_sum[W] ^ sub;
        h_out = low_sum[HALF] ^ sub;
        v_out = (x[W-1] & y_eff[W-1] & ~sum[W-1]) |
                (~x[W-1] & ~y_eff[W-1] & sum[W-1]);
    end
endmodule

// File: rtl/alu8_bitwise.sv
`timescale 1ns/1ps
// Bitwise result path: AND, OR, XOR, one's complement, test, clear and set.
// Assumes the caller ignores its output for arithmetic and unused codes.
module alu8_bitwise #(
    parameter int W = 8
) (
    input  alu8_pkg::alu_op_e op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      res
);
    import alu8_pkg::*;

    // Select the bitwise operation for the current code.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_TST:  res = a & a;
            OP_CLR:  res = a ^ a;
            OP_SER:  res = {W{1'b1}};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flaggen.sv
`timescale 1ns/1ps
// Flag generator: computes all six flag values and the per-operation write
// enables. Assumes result is the final selected result of the ALU.
module alu8_flaggen #(
    parameter int W = 8
) (
    input  alu8_pkg::alu_op_e  op,
    input  logic [W-1:0]       result,
    input  logic               ar_c,
    input  logic               ar_h,
    input  logic               ar_v,
    output alu8_pkg::flag_vec_t flags,
    output alu8_pkg::flag_vec_t flag_we
);
    import alu8_pkg::*;

    logic is_arith;
    logic is_incdec;
    logic is_logic;
    logic is_com;
    logic v_val;

    // Classify the operation into flag-ownership groups.
    always_comb begin
        is_arith  = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
                    (op == OP_SBC) || (op == OP_NEG);
        is_incdec = (op == OP_INC) || (op == OP_DEC);
        is_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                    (op == OP_TST) || (op == OP_CLR);
        is_com    = (op == OP_COM);
    end

    // Compute flag values; overflow is forced low outside add/sub groups.
    always_comb begin
        v_val       = (is_arith || is_incdec) ? ar_v : 1'b0;
        flags       = '0;
        flags[FL_C] = is_com ? 1'b1 : ar_c;
        flags[FL_Z] = (result == '0);
        flags[FL_N] = result[W-1];
        flags[FL_V] = v_val;
        flags[FL_S] = result[W-1] ^ v_val;
        flags[FL_H] = ar_h;
    end

    // Compute which flags this operation is allowed to write.
    always_comb begin
        flag_we       = '0;
        flag_we[FL_Z] = is_arith | is_incdec | is_logic | is_com;
        flag_we[FL_N] = is_arith | is_incdec | is_logic | is_com;
        flag_we[FL_V] = is_arith | is_incdec | is_logic | is_com;
        flag_we[FL_S] = is_arith | is_incdec | is_logic | is_com;
        flag_we[FL_C] = is_arith | is_com;
        flag_we[FL_H] = is_arith;
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
// Top of the 8-bit ALU. Purely combinational: steers operands into the shared
// adder, picks the arithmetic or bitwise result and generates flags plus write
// enables. No clock or reset; the core registers outputs as it needs.
module alu8_core #(
    parameter int W = 8
) (
    input  logic [W-1:0]             op_a,
    input  logic [W-1:0]             op_b,
    input  logic [3:0]               op_sel,
    input  logic                     carry_in,
    output logic [W-1:0]             result,
    output logic [alu8_pkg::NFLAGS-1:0] flags,
    output logic [alu8_pkg::NFLAGS-1:0] flag_we
);
    import alu8_pkg::*;

    alu_op_e      op;
    logic [W-1:0] as_x;
    logic [W-1:0] as_y;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_h;
    logic         as_v;
    logic [W-1:0] bw_res;
    logic         use_adder;
    flag_vec_t    fl_val;
    flag_vec_t    fl_we;

    // Interpret the operation code.
    always_comb op = alu_op_e'(op_sel);

    // Steer operands and carry into the adder for each arithmetic code.
    always_comb begin
        as_x   = (op == OP_NEG) ? '0 : op_a;
        as_y   = (op == OP_NEG) ? op_a :
                 ((op == OP_INC) || (op == OP_DEC)) ? W'(1) : op_b;
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG) || (op == OP_DEC);
        use_adder = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
                    (op == OP_SBC) || (op == OP_NEG) || (op == OP_INC) ||
                    (op == OP_DEC);
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x     (as_x),
        .y     (as_y),
        .cin   (as_cin),
        .sub   (as_sub),
        .sum   (as_sum),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu8_bitwise #(.W(W)) u_bitwise (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (bw_res)
    );

    // Pick the result path.
    always_comb result = use_adder ? as_sum : bw_res;

    alu8_flaggen #(.W(W)) u_flaggen (
        .op      (op),
        .result  (result),
        .ar_c    (as_c),
        .ar_h    (as_h),
        .ar_v    (as_v),
        .flags   (fl_val),
        .flag_we (fl_we)
    );

    // Drive the flag outputs.
    always_comb begin
        flags   = fl_val;
        flag_we = fl_we;
    end
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
// Checker for alu8_core: immediate assertions on the combinational outputs.
// Assumes inputs settle together, as they do when driven from one register stage.
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0]                op_a,
    input logic [3:0]                  op_sel,
    input logic [W-1:0]                result,
    input logic [alu8_pkg::NFLAGS-1:0] flags,
    input logic [alu8_pkg::NFLAGS-1:0] flag_we
);
    import alu8_pkg::*;

    // Evaluate output relations whenever anything changes.
    always_comb begin
        // R8
        set_no_flags_chk: assert (op_sel != OP_SER || (flag_we == '0 && result == {W{1'b1}}))
            else $error("set wrote flags or wrong result");
        // R9
        sign_flag_chk: assert (!flag_we[FL_S] || flags[FL_S] == (flags[FL_N] ^ flags[FL_V]))
            else $error("S differs from N xor V");
        // R5
        com_carry_chk: assert (op_sel != OP_COM || (flags[FL_C] && flag_we[FL_C]))
            else $error("one's complement did not set carry");
        // R6
        incdec_keep_chk: assert (!(op_sel == OP_INC || op_sel == OP_DEC) ||
                                 (!flag_we[FL_C] && !flag_we[FL_H]))
            else $error("inc/dec enabled C or H");
        // R4
        logic_no_ovf_chk: assert (!(op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR ||
                                    op_sel == OP_TST || op_sel == OP_CLR) || !flags[FL_V])
            else $error("logic op raised V");
        // R12
        zero_flag_chk: assert (!flag_we[FL_Z] || flags[FL_Z] == (result == '0))
            else $error("Z disagrees with result");
        // R7
        clear_zero_chk: assert (op_sel != OP_CLR || result == '0 || op_a !== op_a)
            else $error("clear gave nonzero result");
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .op_a    (op_a),
    .op_sel  (op_sel),
    .result  (result),
    .flags   (flags),
    .flag_we (flag_we)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
// Bench for alu8_core: sweeps every code over all A values, a boundary set of
// B values and both carries, against an integer model.
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] op;
    logic       cin;
    logic [7:0] res;
    logic [5:0] fl;
    logic [5:0] we;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .op_a(a), .op_b(b), .op_sel(op), .carry_in(cin),
        .result(res), .flags(fl), .flag_we(we)
    );

    function automatic logic [7:0] bpick(int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
            4: return 8'h10;  5: return 8'h3C;  6: return 8'h7E;  7: return 8'h7F;
            8: return 8'h80;  9: return 8'h81;  10: return 8'hA5; 11: return 8'hC3;
            12: return 8'hEF; 13: return 8'hF0; 14: return 8'hFE; default: return 8'hFF;
        endcase
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0, 1: return "R1";
            2, 3: return "R2";
            8: return "R3";
            4, 5, 6: return "R4";
            7: return "R5";
            9, 10: return "R6";
            11, 12: return "R7";
            13: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Reference model; flag layout {H,S,V,N,Z,C}.
    task automatic model(input int o, input int x, input int y, input int ci,
                         output logic [7:0] r, output logic [5:0] f, output logic [5:0] w);
        int t; int st; logic cc; logic hh; logic vv; logic [7:0] rr;
        cc = 0; hh = 0; vv = 0; rr = 0; w = 0;
        case (o)
            0, 1: begin
                t = x + y + ((o == 1) ? ci : 0); rr = t[7:0]; cc = (t > 255);
                hh = ((x % 16) + (y % 16) + ((o == 1) ? ci : 0)) > 15;
                st = sgn(x) + sgn(y) + ((o == 1) ? ci : 0); vv = (st > 127) || (st < -128);
                w = 6'b111111;
            end
            2, 3, 8: begin
                int p; int q; int k;
                p = (o == 8) ? 0 : x; q = (o == 8) ? x : y; k = (o == 3) ? ci : 0;
                t = p - q - k; rr = t[7:0]; cc = (t < 0);
                hh = ((p % 16) - (q % 16) - k) < 0;
                st = sgn(p) - sgn(q) - k; vv = (st > 127) || (st < -128);
                w = 6'b111111;
            end
            4: begin rr = x[7:0] & y[7:0]; w = 6'b011110; end
            5: begin rr = x[7:0] | y[7:0]; w = 6'b011110; end
            6: begin rr = x[7:0] ^ y[7:0]; w = 6'b011110; end
            7: begin t = 255 - x; rr = t[7:0]; cc = 1; w = 6'b011111; end
            9: begin t = (x + 1) % 256; rr = t[7:0]; vv = (x == 127); w = 6'b011110; end
            10: begin t = (x + 255) % 256; rr = t[7:0]; vv = (x == 128); w = 6'b011110; end
            11: begin rr = x[7:0]; w = 6'b011110; end
            12: begin rr = 8'h00; w = 6'b011110; end
            13: begin rr = 8'hFF; w = 6'b000000; end
            default: begin rr = 8'h00; w = 6'b000000; end
        endcase
        r = rr;
        f = {hh, rr[7] ^ vv, vv, rr[7], (rr == 8'h00), cc};
    endtask

    task automatic check_bits(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input int o, input logic [7:0] x, input logic [7:0] y, input logic c);
        op = o[3:0]; a = x; b = y; cin = c;
        #1;
    endtask

    task automatic sweep_vec(input int o, input int x, input int y, input int ci);
        logic [7:0] r; logic [5:0] f; logic [5:0] w;
        apply(o, x[7:0], y[7:0], ci[0]);
        model(o, x, y, ci, r, f, w);
        checks++;
        if (res !== r || we !== w || (fl & w) !== (f & w)) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h c=%0d: got r=%h f=%b we=%b expected r=%h f=%b we=%b",
                     tag_of(o), o, x[7:0], y[7:0], ci, res, fl & we, we, r, f & w, w);
        end
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; a = 0; b = 0; op = 0; cin = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle state after reset (add of zeros) reports zero result and Z set.
        check_bits("R12 reset result", res, 8'h00);
        check_bits("R12 reset Z", {7'd0, fl[1]}, 8'd1);
        // R10: nibble boundary in both directions.
        apply(0, 8'h0F, 8'h01, 1'b0);
        check_bits("R10 add half-carry", {7'd0, fl[5]}, 8'd1);
        apply(2, 8'h10, 8'h01, 1'b0);
        check_bits("R10 sub half-borrow", {7'd0, fl[5]}, 8'd1);
        // R9: 0x7F+1 gives N=1, V=1, so S=0.
        apply(0, 8'h7F, 8'h01, 1'b0);
        check_bits("R9 sign N^V", {5'd0, fl[4], fl[3], fl[2]}, 8'b011);
        // R12: 0x80+0x80 wraps to zero with carry and overflow.
        apply(0, 8'h80, 8'h80, 1'b0);
        check_bits("R12 wrap zero", {4'd0, fl[3], fl[2], fl[1], fl[0]}, 8'b1011);
        // R2: 0 - 0 - 1 with carry borrows.
        apply(3, 8'h00, 8'h00, 1'b1);
        check_bits("R2 sbc borrow result", res, 8'hFF);
        check_bits("R2 sbc borrow C", {7'd0, fl[0]}, 8'd1);
        // R3: negating 0x80 overflows, negating 0 leaves no borrow.
        apply(8, 8'h80, 8'h00, 1'b0);
        check_bits("R3 neg 0x80 V", {7'd0, fl[3]}, 8'd1);
        apply(8, 8'h00, 8'h00, 1'b1);
        check_bits("R3 neg zero C", {7'd0, fl[0]}, 8'd0);
        // R6: increment of 0xFF wraps without enabling carry.
        apply(9, 8'hFF, 8'h00, 1'b0);
        check_bits("R6 inc wrap", res, 8'h00);
        check_bits("R6 inc no C enable", {7'd0, we[0]}, 8'd0);
        // Full sweep over every code.
        for (int o = 0; o < 16; o++)
            for (int x = 0; x < 256; x++)
                for (int bi = 0; bi < 16; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        sweep_vec(o, x, int'(bpick(bi)), ci);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule